// File: doc/BRIEF.md
# Four-Lane Alignment-Column Deskew

This receive-side block takes four code-group streams, one from each per-lane synchronizer, and lines them up so that every column it emits carries code-groups that the transmitter sent together. The transmitter marks common columns by sending the alignment code-group /A/ on all four lanes in the same cycle. Each lane feeds a small elastic FIFO. While hunting, a lane that sees /A/ parks its read pointer on that code-group and keeps writing behind it. Once every lane holds an /A/ at its head, all four lanes start reading together, so the skew between lanes is absorbed in the FIFOs.

A monitor watches the deskewed output. Four consecutive complete alignment columns raise `align_status`. After that, a column in which only some lanes show /A/ raises a one-cycle `deskew_error`, drops `align_status` and restarts the hunt. Losing sync on any lane also drops `align_status` and restarts the hunt. There is no timer for missing alignment columns, so a long stretch without /A/ leaves alignment in place. The local-fault request is the inverse of `align_status` and goes to the reconciliation logic downstream.

Top module: `lane_deskew_top`

## Requirements
- R1: Each lane carries an 8-bit value plus a control flag. An alignment code-group is control = 1 with value 0x7C. An alignment column has that code-group on all four lanes. Lane n occupies bits [8n+7:8n] of the data buses and bit n of the control and sync buses.
- R2: With lane-to-lane skew of at most DEPTH-1 = 7 cycles, every valid output column holds code-groups from a single transmitted column. The first valid column is an alignment column and appears 2 cycles after the latest lane delivers its /A/.
- R3: When the skew is DEPTH = 8 cycles or more, alignment is never reached. `col_valid` stays low and `align_status` stays low.
- R4: `align_status` rises in the cycle after the fourth consecutive complete alignment column leaves the block. That is 3 cycles after the latest lane delivers its fourth /A/.
- R5: An output column with /A/ on some lanes but not all lanes raises `deskew_error` for exactly one cycle, in the cycle after that column. `align_status` is low in that same cycle.
- R6: After a `deskew_error`, `col_valid` goes low and the hunt restarts. Alignment is then reacquired from the next alignment columns, following the same timing as R2 and R4.
- R7: If any lane's sync input is low on a clock edge, `align_status` and `col_valid` are low after that edge, `deskew_error` is not raised, and the hunt restarts.
- R8: A period with no alignment columns at all, of any length, leaves `align_status` high and raises no `deskew_error`.
- R9: `local_fault_req` is high exactly when `align_status` is low.
- R10: While reset is held, `align_status`, `col_valid` and `deskew_error` are low and `local_fault_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one code-group per lane per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_data | input | 32 | Per-lane code-group values from the synchronizers |
| rx_ctrl | input | 4 | Per-lane control flags |
| rx_sync | input | 4 | Per-lane synchronization status, high when in sync |
| col_data | output | 32 | Deskewed column values |
| col_ctrl | output | 4 | Deskewed column control flags |
| col_valid | output | 1 | The column on col_data/col_ctrl is deskewed |
| align_status | output | 1 | Lanes are aligned (level) |
| deskew_error | output | 1 | Partial alignment column seen (one-cycle pulse) |
| local_fault_req | output | 1 | Request to signal a local fault downstream |

## Verification
An input applied before rising edge n shows its effect after edge n+1 on the column outputs, when it is the latest lane's /A/. A partial column on the output shows up on `deskew_error` and `align_status` one edge later. `align_status` follows the fourth alignment column three edges after it enters. A sync drop acts at the very edge that samples it. The bench drives inputs on the falling edge and reads outputs on the next falling edge, and it counts the rising edges between the two. Each timed check is therefore placed at the exact input index these latencies give, with the neighbouring index checked for the opposite value.

// File: rtl/lane_deskew_pkg.sv
// Shared types and constants for the four-lane deskew block.
// Assumes one code-group per lane per clock, already decoded to
// an 8-bit value plus a control flag by the per-lane synchronizer.
package lane_deskew_pkg;

    localparam int CODE_W = 8;
    localparam logic [CODE_W-1:0] ALIGN_VALUE = 8'h7C;

    typedef struct packed {
        logic              ctrl;
        logic [CODE_W-1:0] value;
    } code_grp_t;

    // True when a code-group is the alignment marker
    function automatic logic is_align(code_grp_t c);
        return c.ctrl && (c.value == ALIGN_VALUE);
    endfunction

endpackage

// File: rtl/lane_fifo.sv
// Per-lane elastic FIFO with an arm-and-hold read pointer.
// Writes one code-group every cycle. While unarmed, the read pointer
// shadows the write pointer. The first alignment code-group arms the
// lane and parks the read pointer on it until the controller says run.
// Assumes DEPTH is a power of two (pointers wrap by bit truncation).
module lane_fifo
    import lane_deskew_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  code_grp_t in_word,
    input  logic      flush,
    input  logic      run,
    output logic      armed,
    output logic      full,
    output code_grp_t head
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam logic [PTR_W:0] FULL_OCC = (PTR_W+1)'(DEPTH);

    code_grp_t        mem [DEPTH];
    logic [PTR_W:0]   wr_ptr;
    logic [PTR_W:0]   rd_ptr;
    logic [PTR_W:0]   occ;

    assign occ  = wr_ptr - rd_ptr;
    assign full = armed && (occ == FULL_OCC);
    assign head = mem[rd_ptr[PTR_W-1:0]];

    // Storage: every incoming code-group is written
    always_ff @(posedge clk) begin
        mem[wr_ptr[PTR_W-1:0]] <= in_word;
    end

    // Pointer and arm control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            armed  <= 1'b0;
        end else begin
            wr_ptr <= wr_ptr + 1'b1;
            if (flush) begin
                armed  <= 1'b0;
                rd_ptr <= wr_ptr;
            end else if (!armed) begin
                rd_ptr <= wr_ptr;
                if (is_align(in_word)) armed <= 1'b1;
            end else if (run) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= FULL_OCC); // R3
    AST_HEAD_IS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed) |-> is_align(head)); // R2

endmodule

// File: rtl/align_monitor.sv
// Watches the deskewed output columns and keeps the alignment status.
// Counts consecutive complete alignment columns to acquire, pulses an
// error on a partial column, and drops status on any lane's sync loss.
// There is deliberately no timer on the absence of alignment columns.
module align_monitor #(
    parameter int LANES    = 4,
    parameter int ACQ_COLS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             col_valid,
    input  logic [LANES-1:0] col_is_a,
    input  logic             sync_all,
    output logic             partial,
    output logic             align_status,
    output logic             deskew_error
);
    localparam int CNT_W = $clog2(ACQ_COLS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACQ_COLS - 1);

    logic             all_a;
    logic [CNT_W-1:0] acq_cnt;

    assign all_a   = &col_is_a;
    assign partial = col_valid && (|col_is_a) && !all_a;

    // Acquisition counter, status level and error pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            align_status <= 1'b0;
            deskew_error <= 1'b0;
            acq_cnt      <= '0;
        end else if (!sync_all) begin
            align_status <= 1'b0;
            deskew_error <= 1'b0;
            acq_cnt      <= '0;
        end else if (partial) begin
            align_status <= 1'b0;
            deskew_error <= 1'b1;
            acq_cnt      <= '0;
        end else begin
            deskew_error <= 1'b0;
            if (col_valid && all_a) begin
                if (acq_cnt >= CNT_LAST) align_status <= 1'b1;
                else                     acq_cnt      <= acq_cnt + 1'b1;
            end
        end
    end

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_error |=> !deskew_error); // R5
    AST_ERR_DROPS_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        deskew_error |-> !align_status); // R5
    AST_SYNC_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_all |=> (!align_status && !deskew_error)); // R7
    AST_ACQ_ON_ALIGN_COL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(align_status) |-> $past(col_valid && all_a)); // R4

endmodule

// File: rtl/lane_deskew_top.sv
// Four-lane deskew: per-lane elastic FIFOs aligned on a common
// alignment column, a registered column output, and the alignment
// monitor. Assumes inputs are code-group aligned per lane and arrive
// one per cycle on every lane.
module lane_deskew_top
    import lane_deskew_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int DEPTH    = 8,
    parameter int ACQ_COLS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [LANES*CODE_W-1:0]   rx_data,
    input  logic [LANES-1:0]          rx_ctrl,
    input  logic [LANES-1:0]          rx_sync,
    output logic [LANES*CODE_W-1:0]   col_data,
    output logic [LANES-1:0]          col_ctrl,
    output logic                      col_valid,
    output logic                      align_status,
    output logic                      deskew_error,
    output logic                      local_fault_req
);
    code_grp_t        in_w  [LANES];
    code_grp_t        heads [LANES];
    logic [LANES-1:0] armed;
    logic [LANES-1:0] full;
    logic [LANES-1:0] col_is_a;
    logic             all_armed;
    logic             sync_all;
    logic             partial;
    logic             flush;
    logic             run;

    assign all_armed = &armed;
    assign sync_all  = &rx_sync;
    assign flush     = !sync_all || partial || ((|full) && !all_armed);
    assign run       = all_armed && !flush;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign in_w[l]     = {rx_ctrl[l], rx_data[l*CODE_W +: CODE_W]};
        assign col_is_a[l] = is_align({col_ctrl[l], col_data[l*CODE_W +: CODE_W]});

        lane_fifo #(.DEPTH(DEPTH)) fifo_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .in_word (in_w[l]),
            .flush   (flush),
            .run     (run),
            .armed   (armed[l]),
            .full    (full[l]),
            .head    (heads[l])
        );

        // Column output register for this lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                col_ctrl[l]                   <= 1'b0;
                col_data[l*CODE_W +: CODE_W]  <= '0;
            end else begin
                col_ctrl[l]                   <= heads[l].ctrl;
                col_data[l*CODE_W +: CODE_W]  <= heads[l].value;
            end
        end
    end

    // Column valid flag: only while all lanes read together
    always_ff @(posedge clk) begin
        if (!rst_n) col_valid <= 1'b0;
        else        col_valid <= run;
    end

    align_monitor #(.LANES(LANES), .ACQ_COLS(ACQ_COLS)) mon_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .col_valid    (col_valid),
        .col_is_a     (col_is_a),
        .sync_all     (sync_all),
        .partial      (partial),
        .align_status (align_status),
        .deskew_error (deskew_error)
    );

    assign local_fault_req = !align_status;

    AST_FIRST_COL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(col_valid) |-> &col_is_a); // R2

endmodule

// File: tb/lane_deskew_top_tb_top.sv
`timescale 1ns/1ps
module lane_deskew_top_tb_top;

    localparam int LANES = 4;
    localparam int APER  = 16;
    localparam int RUNLEN = 110;

    // {skew3, skew2, skew1, skew0, expect_align}
    localparam logic [16:0] VECS [0:5] = '{
        {4'd0, 4'd0, 4'd0, 4'd0, 1'b1},
        {4'd3, 4'd2, 4'd1, 4'd0, 1'b1},
        {4'd1, 4'd5, 4'd0, 4'd3, 1'b1},
        {4'd0, 4'd0, 4'd0, 4'd7, 1'b1},
        {4'd2, 4'd2, 4'd2, 4'd2, 1'b1},
        {4'd0, 4'd8, 4'd0, 4'd0, 1'b0}
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [LANES*8-1:0]   rx_data = '0;
    logic [LANES-1:0]     rx_ctrl = '0;
    logic [LANES-1:0]     rx_sync = '1;
    logic [LANES*8-1:0]   col_data;
    logic [LANES-1:0]     col_ctrl;
    logic                 col_valid;
    logic                 align_status;
    logic                 deskew_error;
    logic                 local_fault_req;

    int errors = 0;
    int checks = 0;
    int n = 0;
    int cur = 0;
    int skew [LANES];
    bit no_a = 0;
    int hole_n = -1;
    int hole_lane = 0;
    int sync_drop_n = -1;

    always #2.5 clk = ~clk;

    lane_deskew_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_data(rx_data), .rx_ctrl(rx_ctrl),
        .rx_sync(rx_sync), .col_data(col_data), .col_ctrl(col_ctrl),
        .col_valid(col_valid), .align_status(align_status),
        .deskew_error(deskew_error), .local_fault_req(local_fault_req)
    );

    function automatic logic [8:0] pat(int m, int lane);
        if (m >= 0 && !no_a && (m % APER) == 0) return {1'b1, 8'h7C};
        return {1'b0, 8'(m * 3 + lane * 17)};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (input index %0d)", req, act, exp, cur);
        end
    endtask

    // Drive input index n at the falling edge, let one rising edge pass,
    // return at the next falling edge with outputs settled
    task automatic cycle();
        for (int l = 0; l < LANES; l++) begin
            logic [8:0] w;
            w = pat(n - skew[l], l);
            if (n == hole_n && l == hole_lane) w = 9'h000;
            rx_ctrl[l]       = w[8];
            rx_data[l*8 +: 8] = w[7:0];
        end
        rx_sync = (n == sync_drop_n) ? 4'b1101 : 4'b1111;
        @(posedge clk);
        @(negedge clk);
        cur = n;
        n++;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        n = -4;
        repeat (4) cycle();
        // R10 reset state
        chk(align_status == 1'b0, "R10 align", int'(align_status), 0);
        chk(col_valid == 1'b0, "R10 valid", int'(col_valid), 0);
        chk(deskew_error == 1'b0, "R10 error", int'(deskew_error), 0);
        chk(local_fault_req == 1'b1, "R10 fault", int'(local_fault_req), 1);
        rst_n = 1'b1;
    endtask

    task automatic check_column();
        // R1/R2: lanes carry the same transmitted column
        if (col_ctrl == 4'b0000) begin
            bit ok = 1;
            for (int l = 1; l < LANES; l++)
                if (col_data[l*8 +: 8] != 8'(col_data[7:0] + l * 17)) ok = 0;
            chk(ok, "R2 column coherence", int'(col_data), 0);
        end else begin
            chk(col_ctrl == 4'b1111 && col_data == {4{8'h7C}}, "R1 align column",
                int'(col_ctrl), 15);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        // Vector table: skew patterns and expected alignment outcome
        for (int v = 0; v < 6; v++) begin
            int maxs;
            int first_valid;
            bit expect_al;
            maxs = 0;
            for (int l = 0; l < LANES; l++) begin
                skew[l] = int'(VECS[v][1 + 4*l +: 4]);
                if (skew[l] > maxs) maxs = skew[l];
            end
            expect_al = VECS[v][0];
            no_a = 0; hole_n = -1; sync_drop_n = -1;
            do_reset();
            first_valid = -1;
            n = 0;
            for (int c = 0; c < RUNLEN; c++) begin
                cycle();
                if (col_valid && first_valid < 0) begin
                    first_valid = cur;
                    chk(col_ctrl == 4'b1111 && col_data == {4{8'h7C}},
                        "R2 first column is alignment", int'(col_ctrl), 15);
                end
                if (cur >= 80 && col_valid) check_column();
            end
            if (expect_al) begin
                chk(first_valid == maxs + 1, "R2 first column latency", first_valid, maxs + 1);
                chk(align_status == 1'b1, "R4 aligned", int'(align_status), 1);
                chk(local_fault_req == 1'b0, "R9 no fault", int'(local_fault_req), 0);
            end else begin
                chk(first_valid == -1, "R3 never valid", first_valid, -1);
                chk(align_status == 1'b0, "R3 not aligned", int'(align_status), 0);
                chk(local_fault_req == 1'b1, "R9 fault", int'(local_fault_req), 1);
            end
        end

        // Directed: acquisition timing, partial column, sync loss, no timer
        for (int l = 0; l < LANES; l++) skew[l] = 0;
        no_a = 0; hole_n = 64; hole_lane = 2; sync_drop_n = 140;
        do_reset();
        n = 0;
        while (n <= 200) begin
            cycle();
            case (cur)
                0:   chk(col_valid == 1'b0, "R2 not yet valid", int'(col_valid), 0);
                1:   chk(col_valid == 1'b1, "R2 valid", int'(col_valid), 1);
                49:  chk(align_status == 1'b0, "R4 before fourth", int'(align_status), 0);
                50:  chk(align_status == 1'b1, "R4 after fourth", int'(align_status), 1);
                65:  chk(deskew_error == 1'b0 && align_status == 1'b1, "R5 not early",
                         int'(deskew_error), 0);
                66: begin
                    chk(deskew_error == 1'b1, "R5 error pulse", int'(deskew_error), 1);
                    chk(align_status == 1'b0, "R5 align drops", int'(align_status), 0);
                    chk(local_fault_req == 1'b1, "R9 fault on error", int'(local_fault_req), 1);
                    chk(col_valid == 1'b0, "R6 valid drops", int'(col_valid), 0);
                end
                67:  chk(deskew_error == 1'b0, "R5 one cycle", int'(deskew_error), 0);
                81:  chk(col_valid == 1'b1, "R6 restart valid", int'(col_valid), 1);
                129: chk(align_status == 1'b0, "R6 reacquire early", int'(align_status), 0);
                130: chk(align_status == 1'b1, "R6 reacquired", int'(align_status), 1);
                139: chk(align_status == 1'b1, "R7 before drop", int'(align_status), 1);
                140: begin
                    chk(align_status == 1'b0, "R7 align drops", int'(align_status), 0);
                    chk(col_valid == 1'b0, "R7 valid drops", int'(col_valid), 0);
                    chk(deskew_error == 1'b0, "R7 no error", int'(deskew_error), 0);
                    chk(local_fault_req == 1'b1, "R9 fault on sync loss", int'(local_fault_req), 1);
                end
                194: chk(align_status == 1'b1, "R7 restart aligned", int'(align_status), 1);
                default: ;
            endcase
        end

        // R8: long stretch without any alignment column
        begin
            bit dropped = 0;
            bit erred = 0;
            no_a = 1;
            repeat (400) begin
                cycle();
                if (!align_status) dropped = 1;
                if (deskew_error) erred = 1;
            end
            chk(!dropped, "R8 align held", int'(dropped), 0);
            chk(!erred, "R8 no error", int'(erred), 0);
            chk(local_fault_req == 1'b0, "R9 no fault", int'(local_fault_req), 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule